// File: doc/BRIEF.md
# DSP Register File Write-Back Formatter

This block holds the data registers of a small fixed-point DSP datapath: two 40-bit accumulators, each an 8-bit guard byte above a 32-bit body, and six 32-bit operand registers (two X, two Y, two M). Each clock it accepts at most one write request made of a destination select, a data word and an operation class. Before storing, it shapes the value according to the class and the kind of destination. The guard bits are sign-extended, cleared or left untouched. The low half is kept or cleared.

Each accumulator also has a guard-only alias. A load to that alias replaces only the guard byte and leaves the body as it was. A request that pairs a destination with a class it cannot take is refused: the block raises an error flag and changes no register. Two combinational read ports return the stored contents.

The reset input asserts at once and is released on a clock edge.

Top module: `dsp_rf_wb`

Encodings:
- Destination and read select `wr_dst`, `rd_sel_*`:
  - 0 = accumulator 0
  - 1 = accumulator 1
  - 2 = guard alias of accumulator 0
  - 3 = guard alias of accumulator 1
  - 4 = X0, 5 = X1, 6 = Y0, 7 = Y1, 8 = M0, 9 = M1
  - 10 to 15 are undefined.
- Class `wr_cls`:
  - 0 = fixed-point
  - 1 = integer
  - 2 = logical
  - 3 = word load
  - 4 = longword load
  - 5 to 7 are undefined.
- Data word `wr_data` (40 bits):
  - A fixed-point result uses all 40 bits.
  - An integer or logical result sits in bits 31..16.
  - Word-load data sits in bits 15..0.
  - Longword-load data sits in bits 31..0.

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A fixed-point write to an accumulator stores all 40 bits of `wr_data` unchanged.
- R3: An integer write to an accumulator stores `wr_data[31:16]` in bits 31..16, copies `wr_data[31]` into bits 39..32 and clears bits 15..0.
- R4: A logical write to an accumulator stores `wr_data[31:16]` in bits 31..16 and clears bits 39..32 and 15..0.
- R5: A word load to an accumulator stores `wr_data[15:0]` in bits 31..16, copies `wr_data[15]` into bits 39..32 and clears bits 15..0.
- R6: A longword load to an accumulator stores `wr_data[31:0]` in bits 31..0 and copies `wr_data[31]` into bits 39..32.
- R7: A word or longword load to a guard alias (select 2 or 3) stores `wr_data[7:0]` in bits 39..32 of that accumulator and leaves its bits 31..0 unchanged.
- R8: A fixed-point write or a longword load to an X, Y or M register stores `wr_data[31:0]`.
- R9: An integer or logical write to an X, Y or M register stores `wr_data[31:16]` in the high half. A word load stores `wr_data[15:0]` there. In both cases the low half is cleared.
- R10: `wr_err` goes high combinationally, with no register changed, when an enabled request does any of the following:
  - sends a fixed-point, integer or logical class to a guard alias;
  - uses a class code above 4;
  - uses a destination code above 9.
- R11: With `wr_en` low no register changes and `wr_err` stays low.
- R12: The read ports are combinational and depend only on their select:
  - An accumulator returns 40 bits.
  - A guard alias returns the guard byte in bits 7..0, with zeros above.
  - An X, Y or M register returns its 32 bits zero-extended.
  - An undefined select returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request valid |
| wr_dst | input | 4 | Destination select |
| wr_cls | input | 3 | Operation class |
| wr_data | input | 40 | Result or load data |
| wr_err | output | 1 | Request refused: illegal destination/class pair |
| rd_sel_a | input | 4 | Read port A select |
| rd_data_a | output | 40 | Read port A data |
| rd_sel_b | input | 4 | Read port B select |
| rd_data_b | output | 40 | Read port B data |

## Verification
- **Guard-only load.** The bench loads an accumulator body and then loads its guard alias. A design that routed the write through the full accumulator path would wipe the body or sign-extend over the new guard byte.
- **Sign-extension source.** It picks data whose sign bit differs between bit 31 and bit 15. A word load that took its sign from the wrong bit, or an integer write that sign-extended where a logical write must clear, then shows a wrong guard byte.
- **Refused requests.** Illegal pairs and undefined codes are mixed into the random stream. A design that stored them anyway, or that flagged them while `wr_en` was low, shows up on the error flag or on a later read.
- **Read zero-fill.** Every select, including the undefined ones, is read back. This catches upper bits left unfilled on operand and guard reads.

// File: rtl/dsp_rf_pkg.sv
package dsp_rf_pkg;

  localparam int SEL_W = 4;
  localparam int CLS_W = 3;
  localparam int N_ACC = 2;
  localparam int N_OP  = 6;

  // First select code of each destination group.
  localparam int GRD_BASE = N_ACC;
  localparam int OP_BASE  = 2 * N_ACC;
  localparam int SEL_END  = OP_BASE + N_OP;

  typedef enum logic [CLS_W-1:0] {
    CLS_FIXP  = 3'd0,
    CLS_INTG  = 3'd1,
    CLS_LOGI  = 3'd2,
    CLS_WLOAD = 3'd3,
    CLS_LLOAD = 3'd4
  } wb_cls_e;

  function automatic logic cls_known(input logic [CLS_W-1:0] c);
    return c <= CLS_W'(CLS_LLOAD);
  endfunction

  function automatic logic cls_is_load(input logic [CLS_W-1:0] c);
    return (c == CLS_W'(CLS_WLOAD)) || (c == CLS_W'(CLS_LLOAD));
  endfunction

endpackage

// File: rtl/dsp_rf_rst_sync.sv
module dsp_rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dsp_rf_fmt.sv
module dsp_rf_fmt
  import dsp_rf_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int BODY_W = 32
) (
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_dst,
  input  logic [CLS_W-1:0]        wr_cls,
  input  logic [ACC_W-1:0]        wr_data,
  output logic [N_ACC-1:0]        body_we,
  output logic [N_ACC-1:0]        guard_we,
  output logic [BODY_W-1:0]       body_d,
  output logic [ACC_W-BODY_W-1:0] guard_d,
  output logic [N_OP-1:0]         op_we,
  output logic [BODY_W-1:0]       op_d,
  output logic                    err
);

  localparam int GUARD_W = ACC_W - BODY_W;
  localparam int HALF_W  = BODY_W / 2;

  logic dst_acc, dst_grd, dst_op, legal;
  logic [HALF_W-1:0] hi_res, word_dat;
  logic [BODY_W-1:0] shaped;
  logic [GUARD_W-1:0] ext_g;

  // Destination group of the request.
  always_comb begin
    dst_acc = wr_dst < SEL_W'(GRD_BASE);
    dst_grd = (wr_dst >= SEL_W'(GRD_BASE)) && (wr_dst < SEL_W'(OP_BASE));
    dst_op  = (wr_dst >= SEL_W'(OP_BASE))  && (wr_dst < SEL_W'(SEL_END));
    legal   = cls_known(wr_cls) &&
              (dst_acc || dst_op || (dst_grd && cls_is_load(wr_cls)));
    err     = wr_en && !legal;
  end

  // Body value and guard extension for each class.
  always_comb begin
    hi_res   = wr_data[BODY_W-1:HALF_W];
    word_dat = wr_data[HALF_W-1:0];
    shaped   = wr_data[BODY_W-1:0];
    ext_g    = '0;
    case (wr_cls)
      CLS_W'(CLS_FIXP): begin
        shaped = wr_data[BODY_W-1:0];
        ext_g  = wr_data[ACC_W-1:BODY_W];
      end
      CLS_W'(CLS_INTG): begin
        shaped = {hi_res, {HALF_W{1'b0}}};
        ext_g  = {GUARD_W{hi_res[HALF_W-1]}};
      end
      CLS_W'(CLS_LOGI): begin
        shaped = {hi_res, {HALF_W{1'b0}}};
        ext_g  = '0;
      end
      CLS_W'(CLS_WLOAD): begin
        shaped = {word_dat, {HALF_W{1'b0}}};
        ext_g  = {GUARD_W{word_dat[HALF_W-1]}};
      end
      CLS_W'(CLS_LLOAD): begin
        shaped = wr_data[BODY_W-1:0];
        ext_g  = {GUARD_W{wr_data[BODY_W-1]}};
      end
      default: begin
        shaped = '0;
        ext_g  = '0;
      end
    endcase
  end

  // The guard alias takes the low byte; a full accumulator takes the extension.
  always_comb begin
    body_d  = shaped;
    op_d    = shaped;
    guard_d = dst_grd ? wr_data[GUARD_W-1:0] : ext_g;
  end

  always_comb begin
    for (int i = 0; i < N_ACC; i++) begin
      body_we[i]  = wr_en && legal && dst_acc && (wr_dst == SEL_W'(i));
      guard_we[i] = wr_en && legal &&
                    ((dst_acc && (wr_dst == SEL_W'(i))) ||
                     (dst_grd && (wr_dst == SEL_W'(GRD_BASE + i))));
    end
    for (int j = 0; j < N_OP; j++) begin
      op_we[j] = wr_en && legal && dst_op && (wr_dst == SEL_W'(OP_BASE + j));
    end
  end

  // R10 / R11: the error flag needs an enabled request, and a raised flag
  // opens no write enable.
  always_comb begin
    assert_err_no_enable_R10:
      assert (!err || ((body_we == '0) && (guard_we == '0) && (op_we == '0)))
      else $error("refused request opened a write enable");
  end

endmodule

// File: rtl/dsp_rf_acc.sv
module dsp_rf_acc #(
  parameter int ACC_W  = 40,
  parameter int BODY_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    body_we,
  input  logic                    guard_we,
  input  logic [BODY_W-1:0]       body_d,
  input  logic [ACC_W-BODY_W-1:0] guard_d,
  output logic [ACC_W-1:0]        acc_q
);

  localparam int GUARD_W = ACC_W - BODY_W;

  logic [BODY_W-1:0]  body_q, body_nx;
  logic [GUARD_W-1:0] guard_q, guard_nx;

  always_comb begin
    body_nx  = body_we  ? body_d  : body_q;
    guard_nx = guard_we ? guard_d : guard_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q  <= '0;
      guard_q <= '0;
    end else begin
      body_q  <= body_nx;
      guard_q <= guard_nx;
    end
  end

  assign acc_q = {guard_q, body_q};

  // R7: a guard-only write leaves the body as it was.
  assert_guard_keeps_body_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (guard_we && !body_we) |=> $stable(acc_q[BODY_W-1:0])
  ) else $error("guard-only write changed accumulator body");

endmodule

// File: rtl/dsp_rf_opreg.sv
module dsp_rf_opreg #(
  parameter int BODY_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BODY_W-1:0] d,
  output logic [BODY_W-1:0] q
);

  logic [BODY_W-1:0] q_nx;

  always_comb begin
    q_nx = we ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

endmodule

// File: rtl/dsp_rf_rdmux.sv
module dsp_rf_rdmux
  import dsp_rf_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int BODY_W = 32
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [N_ACC*ACC_W-1:0]  acc_flat,
  input  logic [N_OP*BODY_W-1:0]  op_flat,
  output logic [ACC_W-1:0]        rd_data
);

  localparam int GUARD_W = ACC_W - BODY_W;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ACC; i++) begin
      if (sel == SEL_W'(i))
        rd_data = acc_flat[i*ACC_W +: ACC_W];
      if (sel == SEL_W'(GRD_BASE + i))
        rd_data = {{BODY_W{1'b0}}, acc_flat[i*ACC_W+BODY_W +: GUARD_W]};
    end
    for (int j = 0; j < N_OP; j++) begin
      if (sel == SEL_W'(OP_BASE + j))
        rd_data = {{GUARD_W{1'b0}}, op_flat[j*BODY_W +: BODY_W]};
    end
  end

endmodule

// File: rtl/dsp_rf_wb.sv
module dsp_rf_wb
  import dsp_rf_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int BODY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_dst,
  input  logic [CLS_W-1:0] wr_cls,
  input  logic [ACC_W-1:0] wr_data,
  output logic             wr_err,
  input  logic [SEL_W-1:0] rd_sel_a,
  output logic [ACC_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0] rd_sel_b,
  output logic [ACC_W-1:0] rd_data_b
);

  localparam int GUARD_W = ACC_W - BODY_W;
  localparam int HALF_W  = BODY_W / 2;

  logic                   rst_sync_n;
  logic [N_ACC-1:0]       body_we, guard_we;
  logic [BODY_W-1:0]      body_d, op_d;
  logic [GUARD_W-1:0]     guard_d;
  logic [N_OP-1:0]        op_we;
  logic [N_ACC*ACC_W-1:0] acc_flat;
  logic [N_OP*BODY_W-1:0] op_flat;

  dsp_rf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dsp_rf_fmt #(.ACC_W(ACC_W), .BODY_W(BODY_W)) u_fmt (
    .wr_en    (wr_en),
    .wr_dst   (wr_dst),
    .wr_cls   (wr_cls),
    .wr_data  (wr_data),
    .body_we  (body_we),
    .guard_we (guard_we),
    .body_d   (body_d),
    .guard_d  (guard_d),
    .op_we    (op_we),
    .op_d     (op_d),
    .err      (wr_err)
  );

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    dsp_rf_acc #(.ACC_W(ACC_W), .BODY_W(BODY_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .body_we  (body_we[i]),
      .guard_we (guard_we[i]),
      .body_d   (body_d),
      .guard_d  (guard_d),
      .acc_q    (acc_flat[i*ACC_W +: ACC_W])
    );
  end

  for (genvar j = 0; j < N_OP; j++) begin : g_op
    dsp_rf_opreg #(.BODY_W(BODY_W)) u_op (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (op_we[j]),
      .d     (op_d),
      .q     (op_flat[j*BODY_W +: BODY_W])
    );
  end

  dsp_rf_rdmux #(.ACC_W(ACC_W), .BODY_W(BODY_W)) u_rd_a (
    .sel      (rd_sel_a),
    .acc_flat (acc_flat),
    .op_flat  (op_flat),
    .rd_data  (rd_data_a)
  );

  dsp_rf_rdmux #(.ACC_W(ACC_W), .BODY_W(BODY_W)) u_rd_b (
    .sel      (rd_sel_b),
    .acc_flat (acc_flat),
    .op_flat  (op_flat),
    .rd_data  (rd_data_b)
  );

  logic half_class;
  assign half_class = (wr_cls == CLS_W'(CLS_INTG)) ||
                      (wr_cls == CLS_W'(CLS_LOGI)) ||
                      (wr_cls == CLS_W'(CLS_WLOAD));

  // R10: a refused request changes no register.
  assert_err_holds_state_R10: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_err) |=> ($stable(acc_flat) && $stable(op_flat))
  ) else $error("refused request changed a register");

  // R11: no enable, no change, no error.
  assert_idle_holds_state_R11: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> ($stable(acc_flat) && $stable(op_flat))
  ) else $error("register changed without a write enable");

  assert_idle_no_err_R11: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    !wr_en |-> !wr_err
  ) else $error("error flag raised without a request");

  // R3: a half-width class to accumulator 0 leaves its low half clear.
  assert_acc0_low_clear_R3: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_err && (wr_dst == SEL_W'(0)) && half_class)
      |=> (acc_flat[HALF_W-1:0] == '0)
  ) else $error("accumulator 0 low half not cleared");

  // R4: a logical write to accumulator 1 clears its guard byte.
  assert_acc1_logic_guard_R4: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_dst == SEL_W'(1)) && (wr_cls == CLS_W'(CLS_LOGI)))
      |=> (acc_flat[ACC_W+BODY_W +: GUARD_W] == '0)
  ) else $error("logical write left accumulator 1 guard set");

  // R9: a half-width class to an operand register clears its low half.
  for (genvar k = 0; k < N_OP; k++) begin : g_chk
    assert_op_low_clear_R9: assert property (
      @(posedge clk) disable iff (!rst_sync_n)
      (wr_en && (wr_dst == SEL_W'(OP_BASE + k)) && half_class)
        |=> (op_flat[k*BODY_W +: HALF_W] == '0)
    ) else $error("operand register low half not cleared");
  end

endmodule

// File: tb/dsp_rf_wb_bench.sv
`timescale 1ns/1ps
module dsp_rf_wb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_dst;
  logic [2:0]  wr_cls;
  logic [39:0] wr_data;
  logic        wr_err;
  logic [3:0]  rd_sel_a, rd_sel_b;
  logic [39:0] rd_data_a, rd_data_b;

  int n_chk  = 0;
  int n_fail = 0;

  logic [39:0] m_acc [2];
  logic [31:0] m_op  [6];

  always #10 clk = ~clk;

  dsp_rf_wb u_dsp_rf_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_dst    (wr_dst),
    .wr_cls    (wr_cls),
    .wr_data   (wr_data),
    .wr_err    (wr_err),
    .rd_sel_a  (rd_sel_a),
    .rd_data_a (rd_data_a),
    .rd_sel_b  (rd_sel_b),
    .rd_data_b (rd_data_b)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic legal(input logic [3:0] d, input logic [2:0] c);
    if (c > 3'd4 || d > 4'd9) return 1'b0;
    if (d == 4'd2 || d == 4'd3) return (c == 3'd3 || c == 3'd4);
    return 1'b1;
  endfunction

  function automatic logic [39:0] rd_exp(input logic [3:0] s);
    if (s < 4'd2) return m_acc[s[0]];
    if (s < 4'd4) return {32'd0, m_acc[s[0]][39:32]};
    if (s < 4'd10) return {8'd0, m_op[s - 4'd4]};
    return 40'd0;
  endfunction

  function automatic string tag_of(input logic [3:0] d, input logic [2:0] c);
    if (!legal(d, c)) return "R10";
    if (d == 4'd2 || d == 4'd3) return "R7";
    if (d < 4'd2) begin
      case (c)
        3'd0: return "R2";
        3'd1: return "R3";
        3'd2: return "R4";
        3'd3: return "R5";
        default: return "R6";
      endcase
    end
    return (c == 3'd0 || c == 3'd4) ? "R8" : "R9";
  endfunction

  task automatic model(input logic [3:0] d, input logic [2:0] c, input logic [39:0] x);
    logic [31:0] body;
    logic [7:0]  g;
    case (c)
      3'd0:    begin body = x[31:0];           g = x[39:32];      end
      3'd1:    begin body = {x[31:16], 16'd0}; g = {8{x[31]}};    end
      3'd2:    begin body = {x[31:16], 16'd0}; g = 8'd0;          end
      3'd3:    begin body = {x[15:0], 16'd0};  g = {8{x[15]}};    end
      default: begin body = x[31:0];           g = {8{x[31]}};    end
    endcase
    if (d < 4'd2)       m_acc[d[0]] = {g, body};
    else if (d < 4'd4)  m_acc[d[0]][39:32] = x[7:0];
    else                m_op[d - 4'd4] = body;
  endtask

  task automatic wr(input logic en, input logic [3:0] d, input logic [2:0] c,
                    input logic [39:0] x, input logic [3:0] sb);
    string t;
    t = en ? tag_of(d, c) : "R11";
    @(negedge clk);
    wr_en = en; wr_dst = d; wr_cls = c; wr_data = x;
    #1 chk({t, " err"}, {39'd0, wr_err}, {39'd0, en && !legal(d, c)});
    @(posedge clk);
    if (en && legal(d, c)) model(d, c, x);
    #1 wr_en = 1'b0;
    rd_sel_a = d; rd_sel_b = sb;
    #1 chk({t, " rdA"}, rd_data_a, rd_exp(d));
    chk("R12 rdB", rd_data_b, rd_exp(sb));
  endtask

  task automatic sweep(input string t);
    for (int s = 0; s < 16; s++) begin
      rd_sel_a = 4'(s); rd_sel_b = 4'(15 - s);
      #1 chk(t, rd_data_a, rd_exp(4'(s)));
      chk(t, rd_data_b, rd_exp(4'(15 - s)));
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [39:0] x;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) m_acc[i] = '0;
    for (int i = 0; i < 6; i++) m_op[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_dst = '0; wr_cls = '0; wr_data = '0;
    rd_sel_a = '0; rd_sel_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep("R1 reset");

    // Directed corner cases.
    wr(1, 4'd0, 3'd0, 40'h80_1234_5678, 4'd1);   // R2
    wr(1, 4'd1, 3'd1, 40'h00_8001_FFFF, 4'd0);   // R3 -> FF_8001_0000
    wr(1, 4'd1, 3'd2, 40'hFF_F00F_FFFF, 4'd0);   // R4 -> 00_F00F_0000
    wr(1, 4'd0, 3'd3, 40'h00_7FFF_8000, 4'd1);   // R5 -> FF_8000_0000
    wr(1, 4'd0, 3'd4, 40'hFF_7FFF_FFFF, 4'd1);   // R6 -> 00_7FFF_FFFF
    wr(1, 4'd2, 3'd3, 40'h00_0000_00A5, 4'd0);   // R7 guard only
    wr(1, 4'd3, 3'd4, 40'hFF_FFFF_FF3C, 4'd1);   // R7
    wr(1, 4'd2, 3'd0, 40'h12_3456_789A, 4'd0);   // R10 guard+fixed
    wr(1, 4'd3, 3'd2, 40'h12_3456_789A, 4'd1);   // R10 guard+logical
    wr(1, 4'd5, 3'd6, 40'h12_3456_789A, 4'd5);   // R10 bad class
    wr(1, 4'd12, 3'd0, 40'h12_3456_789A, 4'd12); // R10 bad dest
    wr(1, 4'd4, 3'd0, 40'hAB_CDEF_1234, 4'd4);   // R8
    wr(1, 4'd6, 3'd3, 40'h00_FFFF_8001, 4'd4);   // R9 word
    wr(1, 4'd9, 3'd1, 40'h00_8765_4321, 4'd6);   // R9 integer
    wr(0, 4'd4, 3'd4, 40'h00_5555_5555, 4'd4);   // R11
    sweep("R12 sweep");

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      x = {8'($urandom), 32'($urandom)};
      wr(($urandom % 10) != 0, 4'($urandom % 12), 3'($urandom % 7), x,
         4'($urandom));
    end
    sweep("R12 final");
    finish_run();
  end

endmodule